// File: doc/BRIEF.md
# Sensor Module Control Command Decoder

This block sits behind the register write path of a smart-sensor module. Software writes a 16-bit command word together with a channel address. Address 0 selects the whole module. Addresses 1 to `NUM_CH` select one channel. In the cycle the write is presented, the decoder turns the word into one-clock action strobes for reset, self-test, calibration and zeroing. A module-scope command fans out to every channel. A channel-scope command reaches only the addressed channel.

Codes that this block does not carry out set a level invalid-command flag. That flag is bit 3 of the module standard status word. It covers the reserved codes, the sequence-sensor codes, the open vendor range and out-of-range channel addresses. A reset command starts a short reset sequence in the state machine. The states are `ST_IDLE`, `ST_RST_HOLD` and `ST_RST_MARK`:

- The transition `IDLE->HOLD` is taken on an accepted reset.
- The transition `HOLD->HOLD` is taken while the hold counter runs.
- The transition `HOLD->MARK` is taken after `RST_CYC` hold cycles.
- The transition `MARK->IDLE` is taken unconditionally.

In `ST_RST_MARK` the has-been-reset flag of the reset's scope is raised for exactly one cycle. Writes that arrive outside `ST_IDLE` are dropped.

Top module: `stim_ctl_decoder`

## Requirements
- R1: Code 0 in any valid scope produces no action strobe and clears the invalid-command flag on the next clock.
- R2: Code 1 at address 0 pulses `stim_rst` and every bit of `chan_rst` in the write cycle.
- R3: Code 1 at address k (1..NUM_CH) pulses only `chan_rst` bit k-1, and `stim_rst` stays low.
- R4: Codes 2, 3 and 4 at address k pulse only bit k-1 of `chan_selftest`, `chan_calib` and `chan_zero` respectively.
- R5: Codes 2, 3 and 4 at address 0 pulse every bit of the matching strobe vector.
- R6: Code 8 and codes 11 to 255 produce no strobe and set `invalid_cmd` on the next clock.
- R7: Codes 5, 6, 7, 9 and 10 (sequence-sensor commands) produce no strobe and set `invalid_cmd`.
- R8: Codes 256 to 65535 produce no strobe and set `invalid_cmd`.
- R9: Any code written to an address above NUM_CH produces no strobe and sets `invalid_cmd`.
- R10: `invalid_cmd` holds its value until the next accepted write, which sets it (bad) or clears it (good).
- R11: After an accepted reset write in cycle t, writes in cycles t+1 to t+RST_CYC+1 are dropped: they produce no strobe and leave `invalid_cmd` unchanged.
- R12: After an accepted reset write in cycle t, the has-been-reset flags are high in cycle t+RST_CYC+1 only. For a module reset, `stim_was_reset` and all `chan_was_reset` bits are high. For a channel reset, only that channel's bit is high.
- R13: Every action strobe is combinational with `cmd_valid`, lasts only while the write is presented, and at most one action per channel fires in a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command write presented this cycle |
| cmd_chan | input | CH_W (3) | Target address, 0 = whole module |
| cmd_code | input | 16 | Command word |
| stim_rst | output | 1 | Module reset strobe |
| chan_rst | output | NUM_CH (4) | Per-channel reset strobes |
| chan_selftest | output | NUM_CH (4) | Per-channel self-test strobes |
| chan_calib | output | NUM_CH (4) | Per-channel calibrate strobes |
| chan_zero | output | NUM_CH (4) | Per-channel zero strobes |
| invalid_cmd | output | 1 | Invalid-command status flag (level) |
| stim_was_reset | output | 1 | Module has-been-reset pulse |
| chan_was_reset | output | NUM_CH (4) | Per-channel has-been-reset pulses |

## Verification
On every cycle, the assertions check the following:
- Each channel sees at most one action at a time.
- No strobe fires outside the idle state.
- A module reset covers every channel.
- Codes from the open range always raise the flag.
- A has-been-reset pulse never lasts two cycles.

Other behaviours need the bench's scenarios. These are the exact mapping of every code and address to its strobe pattern, and the persistence of the invalid flag across idle cycles. They also include the dropping of a write inside the reset window and the cycle and scope of the has-been-reset pulse.

// File: rtl/stim_ctl_pkg.sv
package stim_ctl_pkg;
    typedef enum logic [2:0] {
        OP_NOP,
        OP_RESET,
        OP_SELFTEST,
        OP_CALIB,
        OP_ZERO,
        OP_BAD
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RST_HOLD,
        ST_RST_MARK
    } st_e;
endpackage

// File: rtl/stim_ctl_classify.sv
module stim_ctl_classify
    import stim_ctl_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CH_W   = $clog2(NUM_CH + 1),
    parameter int CODE_W = 16
) (
    input  logic [CH_W-1:0]   chan,
    input  logic [CODE_W-1:0] code,
    output op_e               op,
    output logic              glb
);
    always_comb begin
        glb = (chan == '0);
        if (int'(chan) > NUM_CH) begin
            op = OP_BAD;
        end else begin
            unique case (code)
                CODE_W'(0): op = OP_NOP;
                CODE_W'(1): op = OP_RESET;
                CODE_W'(2): op = OP_SELFTEST;
                CODE_W'(3): op = OP_CALIB;
                CODE_W'(4): op = OP_ZERO;
                default:    op = OP_BAD;
            endcase
        end
    end
endmodule

// File: rtl/stim_ctl_fanout.sv
module stim_ctl_fanout
    import stim_ctl_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CH_W   = $clog2(NUM_CH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  op_e               op,
    input  logic              glb,
    input  logic [CH_W-1:0]   chan,
    output logic              stim_rst,
    output logic [NUM_CH-1:0] rst_v,
    output logic [NUM_CH-1:0] st_v,
    output logic [NUM_CH-1:0] cal_v,
    output logic [NUM_CH-1:0] zr_v
);
    assign stim_rst = fire && glb && (op == OP_RESET);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic sel;
        assign sel      = fire && (glb || (chan == CH_W'(i + 1)));
        assign rst_v[i] = sel && (op == OP_RESET);
        assign st_v[i]  = sel && (op == OP_SELFTEST);
        assign cal_v[i] = sel && (op == OP_CALIB);
        assign zr_v[i]  = sel && (op == OP_ZERO);

        // R13: one action per channel per cycle
        p_one_action_r13: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0({rst_v[i], st_v[i], cal_v[i], zr_v[i]}));
    end
endmodule

// File: rtl/stim_ctl_seq.sv
module stim_ctl_seq
    import stim_ctl_pkg::*;
#(
    parameter int NUM_CH  = 4,
    parameter int CH_W    = $clog2(NUM_CH + 1),
    parameter int RST_CYC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  op_e               op,
    input  logic              glb,
    input  logic [CH_W-1:0]   chan,
    output logic              idle,
    output logic              invalid_cmd,
    output logic              stim_was_reset,
    output logic [NUM_CH-1:0] chan_was_reset
);
    localparam int CNT_W = $clog2(RST_CYC + 1);

    st_e             st, st_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;
    logic            tgt_glb;
    logic [CH_W-1:0] tgt_ch;
    logic            inv_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            cnt     <= '0;
            tgt_glb <= 1'b0;
            tgt_ch  <= '0;
            inv_q   <= 1'b0;
        end else begin
            st  <= st_nx;
            cnt <= cnt_nx;
            if (fire) begin
                inv_q <= (op == OP_BAD);
                if (op == OP_RESET) begin
                    tgt_glb <= glb;
                    tgt_ch  <= chan;
                end
            end
        end
    end

    always_comb begin
        st_nx  = st;
        cnt_nx = '0;
        unique case (st)
            ST_IDLE: begin
                if (fire && (op == OP_RESET)) st_nx = ST_RST_HOLD;
            end
            ST_RST_HOLD: begin
                if (cnt == CNT_W'(RST_CYC - 1)) st_nx = ST_RST_MARK;
                else                           cnt_nx = cnt + 1'b1;
            end
            ST_RST_MARK: st_nx = ST_IDLE;
            default:     st_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        idle           = (st == ST_IDLE);
        invalid_cmd    = inv_q;
        stim_was_reset = (st == ST_RST_MARK) && tgt_glb;
        for (int i = 0; i < NUM_CH; i++) begin
            chan_was_reset[i] = (st == ST_RST_MARK) &&
                                (tgt_glb || (tgt_ch == CH_W'(i + 1)));
        end
    end

    // R12: has-been-reset is a single-cycle pulse
    p_mark_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (|chan_was_reset) |=> !(|chan_was_reset));
endmodule

// File: rtl/stim_ctl_decoder.sv
module stim_ctl_decoder
    import stim_ctl_pkg::*;
#(
    parameter int NUM_CH  = 4,
    parameter int CH_W    = $clog2(NUM_CH + 1),
    parameter int CODE_W  = 16,
    parameter int RST_CYC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [CH_W-1:0]   cmd_chan,
    input  logic [CODE_W-1:0] cmd_code,
    output logic              stim_rst,
    output logic [NUM_CH-1:0] chan_rst,
    output logic [NUM_CH-1:0] chan_selftest,
    output logic [NUM_CH-1:0] chan_calib,
    output logic [NUM_CH-1:0] chan_zero,
    output logic              invalid_cmd,
    output logic              stim_was_reset,
    output logic [NUM_CH-1:0] chan_was_reset
);
    op_e  op;
    logic glb;
    logic idle;
    logic fire;

    assign fire = cmd_valid && idle;

    stim_ctl_classify #(.NUM_CH(NUM_CH), .CH_W(CH_W), .CODE_W(CODE_W)) u_cls (
        .chan(cmd_chan), .code(cmd_code), .op(op), .glb(glb)
    );

    stim_ctl_fanout #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_fan (
        .clk(clk), .rst_n(rst_n), .fire(fire), .op(op), .glb(glb),
        .chan(cmd_chan), .stim_rst(stim_rst), .rst_v(chan_rst),
        .st_v(chan_selftest), .cal_v(chan_calib), .zr_v(chan_zero)
    );

    stim_ctl_seq #(.NUM_CH(NUM_CH), .CH_W(CH_W), .RST_CYC(RST_CYC)) u_seq (
        .clk(clk), .rst_n(rst_n), .fire(fire), .op(op), .glb(glb),
        .chan(cmd_chan), .idle(idle), .invalid_cmd(invalid_cmd),
        .stim_was_reset(stim_was_reset), .chan_was_reset(chan_was_reset)
    );

    // R11: nothing fires while the reset sequence runs
    p_busy_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !idle |-> !(stim_rst || (|chan_rst) || (|chan_selftest) ||
                    (|chan_calib) || (|chan_zero)));

    // R2: a module reset reaches every channel
    p_global_rst_r2: assert property (@(posedge clk) disable iff (!rst_n)
        stim_rst |-> (&chan_rst));

    // R8: open-range codes raise the invalid flag
    p_open_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && idle && (cmd_code >= CODE_W'(256))) |=> invalid_cmd);
endmodule

// File: tb/sim_stim_ctl_decoder.sv
`timescale 1ns/1ps
module sim_stim_ctl_decoder;
    localparam int N  = 4;
    localparam int CW = 3;
    localparam int RC = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [CW-1:0] cmd_chan = '0;
    logic [15:0]   cmd_code = '0;
    logic          stim_rst, invalid_cmd, stim_was_reset;
    logic [N-1:0]  chan_rst, chan_selftest, chan_calib, chan_zero, chan_was_reset;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    stim_ctl_decoder #(.NUM_CH(N), .CH_W(CW), .CODE_W(16), .RST_CYC(RC)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_chan(cmd_chan),
        .cmd_code(cmd_code), .stim_rst(stim_rst), .chan_rst(chan_rst),
        .chan_selftest(chan_selftest), .chan_calib(chan_calib),
        .chan_zero(chan_zero), .invalid_cmd(invalid_cmd),
        .stim_was_reset(stim_was_reset), .chan_was_reset(chan_was_reset)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] strobes();
        return {11'd0, stim_rst, chan_zero, chan_calib, chan_selftest, chan_rst};
    endfunction

    function automatic logic [31:0] flags();
        return {26'd0, invalid_cmd, stim_was_reset, chan_was_reset};
    endfunction

    task automatic issue(input int ch, input int code);
        bit            vch  = (ch <= N);
        bit            good = vch && (code <= 4);
        logic [N-1:0]  mask = (ch == 0) ? {N{1'b1}} : (vch ? N'(1 << (ch - 1)) : '0);
        logic [31:0]   exp;
        string         req;
        if (!vch)                         req = "R9";
        else if (code == 0)               req = "R1";
        else if (code == 1)               req = (ch == 0) ? "R2" : "R3";
        else if (code <= 4)               req = (ch == 0) ? "R5" : "R4";
        else if (code <= 10 && code != 8) req = "R7";
        else if (code >= 256)             req = "R8";
        else                              req = "R6";
        exp = '0;
        if (good) begin
            if (code == 1) begin
                exp[N-1:0] = mask;
                exp[4*N]   = (ch == 0);
            end
            if (code == 2) exp[2*N-1:N]   = mask;
            if (code == 3) exp[3*N-1:2*N] = mask;
            if (code == 4) exp[4*N-1:3*N] = mask;
        end
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_chan  = CW'(ch);
        cmd_code  = 16'(code);
        #1;
        chk(strobes() == exp, req, strobes(), exp);
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(invalid_cmd == !good, (code == 0 && vch) ? "R1" : "R10",
            32'(invalid_cmd), 32'(!good));
        #1;
        chk(strobes() == 0, "R13", strobes(), 0);
        if (good && code == 1) begin
            logic [31:0] fexp;
            cmd_valid = 1'b1;
            cmd_chan  = CW'(1);
            cmd_code  = 16'd99;
            #1;
            chk(strobes() == 0, "R11", strobes(), 0);
            chk(flags() == 0, "R12", flags(), 0);
            for (int j = 1; j <= RC; j++) begin
                @(negedge clk);
                cmd_valid = 1'b0;
                fexp = '0;
                if (j == RC) fexp = {26'd0, 1'b0, (ch == 0), mask};
                chk(flags() == fexp, (j == RC) ? "R12" : "R11", flags(), fexp);
            end
        end
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(strobes() == 0, "R13", strobes(), 0);
        chk(flags() == 0, "R12", flags(), 0);

        for (int ch = 0; ch < 8; ch++) begin
            for (int code = 0; code < 300; code++) issue(ch, code);
            issue(ch, 16'h0100);
            issue(ch, 16'h7FFF);
            issue(ch, 16'hFFFF);
        end

        // R10: invalid flag persists across idle cycles, cleared by a good write
        issue(2, 8);
        repeat (5) @(negedge clk);
        chk(invalid_cmd == 1'b1, "R10", 32'(invalid_cmd), 1);
        issue(3, 2);
        repeat (3) @(negedge clk);
        chk(invalid_cmd == 1'b0, "R10", 32'(invalid_cmd), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule